// File: doc/BRIEF.md
# Two-Bit Burst Address Sequencer

This block produces the address for a four-beat burst access to a synchronous memory. A burst opens when either of two start strobes is high at a rising clock edge. One strobe comes from the processor side and the other from the controller side. On that edge the block captures the full external address. The upper bits stay fixed for the whole burst. On each later edge where the advance input is high, the two low bits move to the next beat.

An order input picks the beat sequence. In linear order the low bits count up modulo four. In interleaved order the low bits are the starting value XOR the beat index. The order is captured together with the address when a burst starts. The order input reads low for interleaved, so a board that leaves it unused should tie it low, which gives the interleaved default. Bursting is optional: a new address can be loaded on every clock edge, and each load shows at the outputs on the following cycle.

Top module: `burst_addr_seq`

## Requirements
- R1: While `rst_n` is low and after its release, until the first start, `addr_hi` and `addr_lo` are zero and the beat index is zero.
- R2: A rising edge with `start_cpu` or `start_ctl` high (either one or both) captures `addr_in`. From the next cycle `{addr_hi, addr_lo}` equals that address.
- R3: A rising edge with no start strobe and `advance` low leaves `addr_hi`, `addr_lo` and the beat index unchanged.
- R4: `addr_hi` changes only on an edge that has a start strobe. Stepping and wrap-around never alter it.
- R5: In linear order (`order_lin` = 1 at the start), after k advances `addr_lo` equals (start low bits + k) mod 4.
- R6: In interleaved order (`order_lin` = 0 at the start), after k advances `addr_lo` equals the start low bits XOR (k mod 4).
- R7: `order_lin` is sampled only on a start edge. Changing it during a burst leaves the running sequence unchanged.
- R8: A start strobe and `advance` on the same edge load the new address at beat zero, and the advance is ignored.
- R9: Start strobes on consecutive edges load a new address every cycle, each visible on the cycle after its edge.
- R10: The fourth advance after a start returns `addr_lo` to the starting low bits, and further advances repeat the sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr_in | input | ADDR_W | External address captured on a start |
| start_cpu | input | 1 | Processor-side burst start strobe |
| start_ctl | input | 1 | Controller-side burst start strobe |
| advance | input | 1 | Step to the next beat |
| order_lin | input | 1 | 1 = linear order, 0 = interleaved order |
| addr_hi | output | ADDR_W-2 | Upper address bits held for the burst |
| addr_lo | output | 2 | Low address bits for the current beat |

## Verification
The assertions assume that every control input is a clean level at each rising edge and that reset is held for at least one edge before use. They also assume the order input matters only through the value captured at a start. The bench changes inputs only at falling edges and keeps the controls at known 0/1 values. It drives a changing order input in the middle of bursts so that any dependence on its live value would show up. Start and advance are combined in every pattern: start alone, advance alone, both together, neither, and starts on back-to-back edges.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;

  localparam int unsigned BEAT_W = 2;

  typedef logic [BEAT_W-1:0] beat_t;

  typedef enum logic {
    ORD_ILV = 1'b0,
    ORD_LIN = 1'b1
  } order_e;

  // Beat index after one advance; wraps modulo four.
  function automatic beat_t beat_inc(input beat_t k);
    return beat_t'(k + beat_t'(1));
  endfunction

  // Linear order: count up from the starting low bits.
  function automatic beat_t lo_linear(input beat_t s, input beat_t k);
    return beat_t'(s + k);
  endfunction

  // Interleaved order: flip starting low bits by the beat index.
  function automatic beat_t lo_interleave(input beat_t s, input beat_t k);
    return s ^ k;
  endfunction

endpackage

// File: rtl/bseq_start_merge.sv
module bseq_start_merge #(
  parameter int unsigned N_SRC = 2
) (
  input  logic [N_SRC-1:0] strobes,
  input  logic             advance,
  output logic             load_evt,
  output logic             step_evt
);

  logic [N_SRC:0] any_chain;

  assign any_chain[0] = 1'b0;

  generate
    for (genvar i = 0; i < N_SRC; i++) begin : g_or
      assign any_chain[i+1] = any_chain[i] | strobes[i];
    end
  endgenerate

  // A start always wins over an advance on the same edge.
  assign load_evt = any_chain[N_SRC];
  assign step_evt = advance & ~load_evt;

endmodule

// File: rtl/bseq_addr_reg.sv
module bseq_addr_reg
  import burst_seq_pkg::*;
#(
  parameter int unsigned ADDR_W = 20,
  localparam int unsigned HI_W = ADDR_W - BEAT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_evt,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic              order_lin,
  output logic [HI_W-1:0]   hi_q,
  output beat_t             base_lo_q,
  output order_e            order_q
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hi_q      <= '0;
      base_lo_q <= '0;
      order_q   <= ORD_ILV;
    end else if (load_evt) begin
      hi_q      <= addr_in[ADDR_W-1:BEAT_W];
      base_lo_q <= addr_in[BEAT_W-1:0];
      order_q   <= order_lin ? ORD_LIN : ORD_ILV;
    end
  end

endmodule

// File: rtl/bseq_beat_ctr.sv
module bseq_beat_ctr
  import burst_seq_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  load_evt,
  input  logic  step_evt,
  output beat_t beat_q
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      beat_q <= '0;
    end else if (load_evt) begin
      beat_q <= '0;
    end else if (step_evt) begin
      beat_q <= beat_inc(beat_q);
    end
  end

endmodule

// File: rtl/bseq_order_map.sv
module bseq_order_map
  import burst_seq_pkg::*;
(
  input  beat_t  base_lo,
  input  beat_t  beat,
  input  order_e order,
  output beat_t  lo
);

  beat_t lin_val;
  beat_t ilv_val;

  assign lin_val = lo_linear(base_lo, beat);
  assign ilv_val = lo_interleave(base_lo, beat);

  generate
    for (genvar b = 0; b < BEAT_W; b++) begin : g_sel
      assign lo[b] = (order == ORD_LIN) ? lin_val[b] : ilv_val[b];
    end
  endgenerate

endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
  import burst_seq_pkg::*;
#(
  parameter int unsigned ADDR_W = 20,
  localparam int unsigned HI_W = ADDR_W - BEAT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic              start_cpu,
  input  logic              start_ctl,
  input  logic              advance,
  input  logic              order_lin,
  output logic [HI_W-1:0]   addr_hi,
  output logic [BEAT_W-1:0] addr_lo
);

  // Named internal events, visible to the bound checker.
  logic   load_evt;
  logic   step_evt;
  beat_t  beat_cnt;
  beat_t  base_lo;
  order_e order_q;
  beat_t  lo_mapped;

  bseq_start_merge #(.N_SRC(2)) u_merge (
    .strobes  ({start_ctl, start_cpu}),
    .advance  (advance),
    .load_evt (load_evt),
    .step_evt (step_evt)
  );

  bseq_addr_reg #(.ADDR_W(ADDR_W)) u_areg (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_evt  (load_evt),
    .addr_in   (addr_in),
    .order_lin (order_lin),
    .hi_q      (addr_hi),
    .base_lo_q (base_lo),
    .order_q   (order_q)
  );

  bseq_beat_ctr u_ctr (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_evt (load_evt),
    .step_evt (step_evt),
    .beat_q   (beat_cnt)
  );

  bseq_order_map u_map (
    .base_lo (base_lo),
    .beat    (beat_cnt),
    .order   (order_q),
    .lo      (lo_mapped)
  );

  assign addr_lo = lo_mapped;

endmodule

// File: rtl/burst_addr_seq_chk.sv
module burst_addr_seq_chk #(
  parameter int unsigned ADDR_W = 20,
  localparam int unsigned HI_W = ADDR_W - 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] addr_in,
  input logic              load_evt,
  input logic              step_evt,
  input logic [1:0]        beat_cnt,
  input logic              order_q,
  input logic [HI_W-1:0]   addr_hi,
  input logic [1:0]        addr_lo
);

  a_r2_load_captures: assert property (@(posedge clk) disable iff (!rst_n)
    load_evt |=> ({addr_hi, addr_lo} == $past(addr_in)));

  a_r3_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_evt && !step_evt) |=> ($stable(addr_hi) && $stable(addr_lo) && $stable(beat_cnt)));

  a_r4_upper_fixed: assert property (@(posedge clk) disable iff (!rst_n)
    !load_evt |=> $stable(addr_hi));

  a_r5_linear_step: assert property (@(posedge clk) disable iff (!rst_n)
    (step_evt && order_q) |=> (addr_lo == 2'($past(addr_lo) + 2'd1)));

  a_r6_interleave_step: assert property (@(posedge clk) disable iff (!rst_n)
    (step_evt && !order_q) |=>
      ((addr_lo ^ $past(addr_lo)) == ($past(beat_cnt) ^ 2'($past(beat_cnt) + 2'd1))));

  a_r7_order_latched: assert property (@(posedge clk) disable iff (!rst_n)
    !load_evt |=> $stable(order_q));

  a_r8_start_wins: assert property (@(posedge clk) disable iff (!rst_n)
    load_evt |=> (beat_cnt == 2'd0));

endmodule

bind burst_addr_seq burst_addr_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .addr_in  (addr_in),
  .load_evt (load_evt),
  .step_evt (step_evt),
  .beat_cnt (beat_cnt),
  .order_q  (order_q),
  .addr_hi  (addr_hi),
  .addr_lo  (addr_lo)
);

// File: tb/burst_addr_seq_tb.sv
module burst_addr_seq_tb;

  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W     = 20;
  localparam int HI_W       = ADDR_W - 2;

  logic              clk = 1'b0;
  logic              rst_n;
  logic [ADDR_W-1:0] addr_in;
  logic              start_cpu, start_ctl, advance, order_lin;
  logic [HI_W-1:0]   addr_hi;
  logic [1:0]        addr_lo;

  int n_tests = 0;
  int n_fail  = 0;

  typedef struct {
    logic [HI_W-1:0] hi;
    logic [1:0]      lo;
    string           tag;
  } exp_t;

  exp_t exp_q[$];

  // Reference state, kept by the bench from the requirements.
  logic [HI_W-1:0] m_hi;
  logic [1:0]      m_s;
  int              m_k;
  logic            m_lin;

  always #(CLK_PERIOD/2) clk = ~clk;

  burst_addr_seq #(.ADDR_W(ADDR_W)) u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .addr_in   (addr_in),
    .start_cpu (start_cpu),
    .start_ctl (start_ctl),
    .advance   (advance),
    .order_lin (order_lin),
    .addr_hi   (addr_hi),
    .addr_lo   (addr_lo)
  );

  function automatic logic [1:0] model_lo();
    logic [1:0] v;
    if (m_lin) begin
      v = m_s;
      for (int i = 0; i < (m_k % 4); i++) v = v + 2'd1;
    end else begin
      v = m_s ^ 2'(m_k % 4);
    end
    return v;
  endfunction

  task automatic compare(input string tag, input logic [HI_W-1:0] ehi, input logic [1:0] elo);
    n_tests++;
    if (addr_hi !== ehi || addr_lo !== elo) begin
      n_fail++;
      $display("FAIL %s: got hi=%h lo=%0d, expected hi=%h lo=%0d", tag, addr_hi, addr_lo, ehi, elo);
    end
  endtask

  // Driver: apply one edge's inputs, update the model, queue the expectation.
  task automatic cyc(input logic c, input logic t, input logic a, input logic lin,
                     input logic [ADDR_W-1:0] ad, input string tag);
    exp_t e;
    @(negedge clk);
    start_cpu = c; start_ctl = t; advance = a; order_lin = lin; addr_in = ad;
    @(posedge clk);
    if (c || t) begin
      m_hi = ad[ADDR_W-1:2]; m_s = ad[1:0]; m_k = 0; m_lin = lin;
    end else if (a) begin
      m_k = m_k + 1;
    end
    e.hi = m_hi; e.lo = model_lo(); e.tag = tag;
    exp_q.push_back(e);
  endtask

  // Monitor: compare at the falling edge after each queued edge.
  initial begin
    forever begin
      @(negedge clk);
      if (exp_q.size() > 0) begin
        exp_t e;
        e = exp_q.pop_front();
        compare(e.tag, e.hi, e.lo);
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    n_tests++; n_fail++;
    $display("FAIL watchdog: got hang, expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; start_cpu = 0; start_ctl = 0; advance = 0; order_lin = 0;
    addr_in = '0;
    m_hi = '0; m_s = '0; m_k = 0; m_lin = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    compare("R1 in reset", '0, 2'd0);
    rst_n = 1'b1;
    // R1: idle after reset keeps zero
    cyc(0, 0, 0, 0, 20'hFFFFF, "R1 idle after reset");

    // R6, R10: interleaved from low=1 via processor strobe
    cyc(1, 0, 0, 0, 20'h12345, "R2 cpu load");
    for (int i = 0; i < 6; i++) cyc(0, 0, 1, 0, 20'h0, "R6 R10 interleave step");

    // R5, R4, R10: linear from low=2 via controller strobe, wrap keeps upper
    cyc(0, 1, 0, 1, 20'hABCDE, "R2 ctl load");
    for (int i = 0; i < 5; i++) cyc(0, 0, 1, 1, 20'h00001, "R5 R4 linear step");

    // R3: hold while idle, even with address churn
    cyc(0, 0, 0, 0, 20'h55555, "R3 hold");
    cyc(0, 0, 0, 1, 20'hAAAAA, "R3 hold");

    // R7: change order input mid-burst
    cyc(1, 0, 0, 1, 20'h00F03, "R7 load linear");
    cyc(0, 0, 1, 0, 20'h0, "R7 order change ignored");
    cyc(0, 0, 1, 0, 20'h0, "R7 order change ignored");
    cyc(1, 0, 0, 0, 20'h00F03, "R7 load interleave");
    cyc(0, 0, 1, 1, 20'h0, "R7 order change ignored");
    cyc(0, 0, 1, 1, 20'h0, "R7 order change ignored");

    // R8: start and advance together
    cyc(0, 0, 1, 0, 20'h0, "R6 step");
    cyc(1, 0, 1, 0, 20'h7777E, "R8 cpu start wins");
    cyc(0, 0, 1, 0, 20'h0, "R6 step after R8");
    cyc(0, 1, 1, 1, 20'h33331, "R8 ctl start wins");
    cyc(1, 1, 1, 1, 20'h44442, "R8 R2 both strobes");

    // R9: a new address every edge
    for (int i = 0; i < 8; i++)
      cyc(i[0], ~i[0], i[1], i[2], 20'(32'h9000 + i * 32'h1357), "R9 back-to-back");

    // R5, R6 from every start value in both orders
    for (int s = 0; s < 4; s++) begin
      for (int o = 0; o < 2; o++) begin
        cyc(1, 0, 0, o[0], 20'(32'hC0000 + s), "R2 sweep load");
        for (int k = 0; k < 4; k++)
          cyc(0, 0, 1, ~o[0], 20'h0, o[0] ? "R5 sweep" : "R6 sweep");
      end
    end

    repeat (3) @(negedge clk);
    n_tests++;
    if (exp_q.size() != 0) begin
      n_fail++;
      $display("FAIL R2 queue: got %0d pending, expected 0", exp_q.size());
    end
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule